// File: doc/BRIEF.md
# Clock Bank Divider with Per-Output Enables

This block takes one already-selected source clock and drives a bank of output clocks. The bank runs either at the source rate or at half the source rate. Each output has its own drive-enable, which stands in for a tri-state pad. The source clock arrives as a level that is sampled by a faster system clock `clk_i`. The divided waveform is rebuilt in that domain. A separate flag, `src_bad_i`, comes from an upstream stall detector and marks the source as dead.

The ratio select and the per-output enables are asynchronous control pins. Each passes through a two-flop synchroniser. A new ratio takes effect only at the start of a divided period, so the output never shows a short pulse. Turning an output off lets its high phase finish before the drive-enable is released. Turning an output on first drives it low, so the first visible edge is a rising edge. While the source is dead, the bank is held low and an output that is turned off is released at once. When the source recovers, the bank stays low until the first source rising edge and then runs at the ratio selected at that moment.

Top module: `clk_bank_div`

## Requirements
- R1: `div_sel_i` = 0 selects divide-by-1 and the output period equals the source period. `div_sel_i` = 1 selects divide-by-2, giving twice the source period with a 50% duty cycle.
- R2: A change of `div_sel_i` is applied only at a source rising edge that begins a new output period. No driven output ever shows a high or low pulse shorter than half a source period.
- R3: After reset every drive-enable is high, every output is low, and the ratio is divide-by-1.
- R4: Each bit of `oe_i` controls only its own output. The other outputs keep running unchanged.
- R5: When `oe_i[n]` falls with a healthy source, `q_oe_o[n]` drops only after `q_o[n]` has been low for a cycle. A high phase is never cut short.
- R6: When `oe_i[n]` rises, `q_oe_o[n]` rises while `q_o[n]` is low. The output stays driven low for at least one cycle before its first rising edge.
- R7: One clock after `src_bad_i` is seen high, every `q_o` bit is low.
- R8: While `src_bad_i` is high and output n is running, a falling `oe_i[n]` drops `q_oe_o[n]` on exactly the third `clk_i` rising edge after the change. Two of those edges are synchroniser delay.
- R9: After `src_bad_i` clears, the outputs stay low until the first source rising edge. From that edge they run at the ratio selected at that time, including a ratio changed while the source was bad.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock that samples the source |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_clk_i | input | 1 | Level of the selected source clock |
| src_bad_i | input | 1 | Source stall flag from the detector |
| div_sel_i | input | 1 | Ratio select: 0 divide-by-1, 1 divide-by-2 |
| oe_i | input | NUM_OUT | Per-output enable, active high, asynchronous |
| q_o | output | NUM_OUT | Output clock levels |
| q_oe_o | output | NUM_OUT | Per-output drive-enable (0 = high impedance) |

## Verification
The divider follows a source edge on the next `clk_i` edge. `src_bad_i` forces the outputs low on the next edge. A control pin reaches the output state machines after two synchroniser edges, and they react on the third edge. A ratio change then waits for the next period boundary, so ratio checks skip ahead by tens of cycles and measure rise-to-rise periods. The timing of the disable while the source is dead is checked at the second and third edges exactly. All sampling happens on the falling edge of `clk_i`. A monitor logs every pulse shorter than half a source period, and every drive release that cuts a high phase short.

// File: rtl/clk_bank_div_pkg.sv
package clk_bank_div_pkg;
  typedef enum logic {DIV_BY1 = 1'b0, DIV_BY2 = 1'b1} div_mode_e;
  typedef enum logic [1:0] {OG_OFF, OG_ARM, OG_RUN, OG_DRAIN} og_state_e;
endpackage

// File: rtl/clk_bank_sync.sv
module clk_bank_sync #(
  parameter int unsigned WIDTH = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/clk_bank_core.sv
module clk_bank_core
  import clk_bank_div_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic src_clk_i,
  input  logic src_bad_i,
  input  logic div_sel_i,
  output logic base_o
);
  logic      src_q, base_q, hold_q, rise;
  logic      base_n;
  div_mode_e cur_q, sel_n;

  assign rise = src_clk_i & ~src_q;

  always_comb begin
    sel_n = cur_q;
    // period boundary: source rise while the divided clock is low
    if (rise && !base_q && !src_bad_i) sel_n = div_mode_e'(div_sel_i);
    if (src_bad_i)            base_n = 1'b0;
    else if (hold_q)          base_n = rise;
    else if (sel_n == DIV_BY1) base_n = src_clk_i;
    else                      base_n = rise ? ~base_q : base_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q  <= 1'b0;
      base_q <= 1'b0;
      hold_q <= 1'b1;
      cur_q  <= DIV_BY1;
    end else begin
      src_q  <= src_clk_i;
      base_q <= base_n;
      cur_q  <= sel_n;
      if (src_bad_i) hold_q <= 1'b1;
      else if (rise) hold_q <= 1'b0;
    end
  end

  assign base_o = base_q;

  a_r7_bad_forces_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_bad_i |=> !base_q);
  a_r2_ratio_at_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_q != $past(cur_q)) |-> !$past(base_q));
  a_r9_hold_until_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_q && !src_bad_i && !rise) |=> !base_q);
endmodule

// File: rtl/clk_bank_gate.sv
module clk_bank_gate
  import clk_bank_div_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic bad_i,
  input  logic base_i,
  output logic q_o,
  output logic oe_o
);
  og_state_e st_q, st_n;

  always_comb begin
    st_n = st_q;
    unique case (st_q)
      OG_OFF:   if (en_i) st_n = OG_ARM;
      OG_ARM:   if (!en_i) st_n = OG_OFF;
                else if (!base_i) st_n = OG_RUN;
      OG_RUN:   if (!en_i) st_n = bad_i ? OG_OFF : OG_DRAIN;
      OG_DRAIN: if (en_i) st_n = OG_RUN;
                else if (bad_i || !base_i) st_n = OG_OFF;
      default:  st_n = OG_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= OG_ARM;
    else         st_q <= st_n;
  end

  assign oe_o = (st_q != OG_OFF);
  assign q_o  = base_i & ((st_q == OG_RUN) | (st_q == OG_DRAIN));

  a_r5_release_when_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(oe_o) && !$past(bad_i)) |-> !$past(q_o));
  a_r6_driven_before_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(q_o) |-> $past(oe_o));
  a_r6_enable_starts_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_o) |-> !q_o);
endmodule

// File: rtl/clk_bank_div.sv
module clk_bank_div
  import clk_bank_div_pkg::*;
#(
  parameter int unsigned NUM_OUT = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               src_clk_i,
  input  logic               src_bad_i,
  input  logic               div_sel_i,
  input  logic [NUM_OUT-1:0] oe_i,
  output logic [NUM_OUT-1:0] q_o,
  output logic [NUM_OUT-1:0] q_oe_o
);
  localparam logic [NUM_OUT-1:0] OE_RST = {NUM_OUT{1'b1}};

  logic               div_sel_s, base;
  logic [NUM_OUT-1:0] oe_s;

  clk_bank_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_div (
    .clk_i, .rst_ni, .d_i(div_sel_i), .q_o(div_sel_s));

  clk_bank_sync #(.WIDTH(NUM_OUT), .STAGES(SYNC_STAGES), .RST_VAL(OE_RST)) u_sync_oe (
    .clk_i, .rst_ni, .d_i(oe_i), .q_o(oe_s));

  clk_bank_core u_core (
    .clk_i, .rst_ni, .src_clk_i, .src_bad_i,
    .div_sel_i(div_sel_s), .base_o(base));

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
    clk_bank_gate u_gate (
      .clk_i, .rst_ni, .en_i(oe_s[g]), .bad_i(src_bad_i), .base_i(base),
      .q_o(q_o[g]), .oe_o(q_oe_o[g]));
  end

  a_r7_bank_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_bad_i |=> (q_o == '0));
endmodule

// File: tb/clk_bank_div_test.sv
`timescale 1ns/1ps
module clk_bank_div_test;
  localparam int N = 4;
  localparam int HALF_SRC = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic src_clk = 1'b0, src_bad = 1'b0, div_sel = 1'b0;
  logic [N-1:0] oe = '1;
  logic [N-1:0] q, q_oe;
  logic src_run = 1'b1;
  int   src_cnt = 0;
  int   errors = 0, checks = 0, glitches = 0;
  logic mon_en = 1'b0;
  int   run_len [N];
  logic pq [N], poe [N], seen_fall [N];

  clk_bank_div #(.NUM_OUT(N)) uut (
    .clk_i(clk), .rst_ni(rst_n), .src_clk_i(src_clk), .src_bad_i(src_bad),
    .div_sel_i(div_sel), .oe_i(oe), .q_o(q), .q_oe_o(q_oe));

  always #10 clk = ~clk;

  initial forever begin
    @(negedge clk);
    if (src_run) begin
      if (src_cnt == HALF_SRC - 1) begin src_clk = ~src_clk; src_cnt = 0; end
      else src_cnt++;
    end
  end

  // pulse-width monitor
  initial begin
    for (int i = 0; i < N; i++) begin run_len[i] = 0; pq[i] = 0; poe[i] = 0; seen_fall[i] = 0; end
    forever begin
      @(negedge clk);
      for (int i = 0; i < N; i++) begin
        if (mon_en && poe[i] && !q_oe[i] && pq[i]) glitches++;
        if (q_oe[i] && poe[i] && q[i] != pq[i]) begin
          if (mon_en && pq[i] && run_len[i] < HALF_SRC) glitches++;
          if (mon_en && !pq[i] && seen_fall[i] && run_len[i] < HALF_SRC) glitches++;
          if (pq[i]) seen_fall[i] = 1;
          run_len[i] = 1;
        end else run_len[i]++;
        if (!q_oe[i]) seen_fall[i] = 0;
        pq[i] = q[i];
        poe[i] = q_oe[i];
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic meas_period(input int b, output int per);
    logic p;
    int n;
    per = -1;
    p = q[b];
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (!p && q[b]) begin
        n = 0; p = q[b];
        for (int j = 0; j < 200; j++) begin
          @(negedge clk); n++;
          if (!p && q[b]) begin per = n; return; end
          p = q[b];
        end
        return;
      end
      p = q[b];
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(q_oe == '1, "R3 oe after reset", q_oe, 15);
    chk(q == '0, "R3 q after reset", q, 0);
  endtask

  task automatic t_div1;
    int per;
    meas_period(0, per);
    chk(per == 2*HALF_SRC, "R1 div1 period q0", per, 2*HALF_SRC);
    meas_period(3, per);
    chk(per == 2*HALF_SRC, "R3 default div1 q3", per, 2*HALF_SRC);
  endtask

  task automatic t_div_switch;
    int per;
    glitches = 0;
    @(negedge clk); div_sel = 1'b1;
    repeat (40) @(negedge clk);
    meas_period(0, per);
    chk(per == 4*HALF_SRC, "R1 div2 period", per, 4*HALF_SRC);
    div_sel = 1'b0;
    repeat (40) @(negedge clk);
    meas_period(2, per);
    chk(per == 2*HALF_SRC, "R1 back to div1", per, 2*HALF_SRC);
    chk(glitches == 0, "R2 no short pulse on ratio change", glitches, 0);
  endtask

  task automatic t_disable;
    int per, k;
    glitches = 0;
    @(negedge clk); oe[1] = 1'b0;
    for (k = 0; k < 30 && q_oe[1]; k++) @(negedge clk);
    chk(!q_oe[1], "R5 output released", q_oe[1], 0);
    chk(q_oe == 4'b1101, "R4 other outputs still driven", q_oe, 13);
    meas_period(0, per);
    chk(per == 2*HALF_SRC, "R4 q0 unaffected", per, 2*HALF_SRC);
    chk(glitches == 0, "R5 high phase not truncated", glitches, 0);
  endtask

  task automatic t_enable;
    int per, k;
    glitches = 0;
    @(negedge clk); oe[1] = 1'b1;
    for (k = 0; k < 30 && !q_oe[1]; k++) @(negedge clk);
    chk(q_oe[1] && !q[1], "R6 enable starts driven low", q[1], 0);
    meas_period(1, per);
    chk(per == 2*HALF_SRC, "R6 q1 running again", per, 2*HALF_SRC);
    chk(glitches == 0, "R6 clean first edge", glitches, 0);
  endtask

  task automatic t_bad;
    mon_en = 1'b0;
    @(negedge clk); src_run = 1'b0; src_clk = 1'b1; src_bad = 1'b1;
    @(negedge clk);
    chk(q == '0, "R7 bank low while bad", q, 0);
    repeat (5) @(negedge clk);
    oe[2] = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk(q_oe[2], "R8 still driven after two edges", q_oe[2], 1);
    @(posedge clk); @(negedge clk);
    chk(!q_oe[2], "R8 released on third edge", q_oe[2], 0);
  endtask

  task automatic t_recover;
    int per;
    div_sel = 1'b1;
    repeat (6) @(negedge clk);
    src_bad = 1'b0;
    repeat (6) @(negedge clk);
    chk(q == '0, "R9 low until first source rise", q, 0);
    src_cnt = 0; src_run = 1'b1;
    meas_period(0, per);
    chk(per == 4*HALF_SRC, "R9 new ratio after recovery", per, 4*HALF_SRC);
  endtask

  initial begin
    #(100000 * 20);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    repeat (4) @(negedge clk);
    mon_en = 1'b1;
    t_div1();
    t_div_switch();
    t_disable();
    t_enable();
    t_bad();
    t_recover();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule